// File: doc/BRIEF.md
# Multi-format serial audio port

This block is the slave side of a stereo serial audio link. The bit clock and the word select come from an external master and are oversampled on the local system clock. Incoming playback words are turned into a pair of parallel left/right samples, delivered with a one-cycle strobe once per frame. At the same time the block serialises a pair of parallel record samples onto the output data line. Left and right words share the data lines in time. Word select low carries the left channel and word select high carries the right channel.

A 3-bit format code sets how a word sits inside its half-frame. In the delayed mode the MSB follows the word-select change by one bit period. In the left-aligned mode the MSB sits in the bit period where word select changes. In the right-aligned mode a 16, 18 or 20-bit word ends in the last bit period before the next word-select change. Three combined codes send left-aligned output while receiving right-aligned input. The input and the output therefore do not have to use the same alignment.

Top module: `serial_audio_port`

## Requirements
- R1: The format code decodes as follows. 000 is delayed in both directions. 100 is left-aligned in both directions. 001, 010 and 011 are right-aligned in both directions with 16, 18 and 20-bit words. 101, 110 and 111 are left-aligned 24-bit output with right-aligned 16, 18 and 20-bit input.
- R2: Bits sent or received while word select is low belong to the left channel. Bits sent or received while word select is high belong to the right channel.
- R3: Delayed mode: bit 23 (the MSB) is in bit period 1, counted from 0 at the word-select change, and up to 24 bits follow in descending order. Received bits that the slot does not carry read as zero.
- R4: Left-aligned mode: bit 23 is in bit period 0, the period of the word-select change. Up to 24 bits follow, and bits the slot does not carry read as zero on receive.
- R5: Right-aligned receive: the last N bits of a half-frame (N = 16, 18 or 20) form the word, LSB last. The word is sign-extended from bit N-1 to 24 bits. Earlier bits of the half-frame are ignored.
- R6: Right-aligned transmit: bits N-1..0 of the record sample fill the last N bit periods of the half-frame, LSB last. The half-frame length is taken from the previous half-frame. Record bits above N-1 are not sent.
- R7: The output line is zero in every bit period that carries no word bit. It changes only in response to a bit-clock falling edge.
- R8: Input data is taken at bit-clock rising edges.
- R9: The sample-valid strobe is high for exactly one system-clock cycle per frame. It rises one cycle after the rising edge that sees word select go from high to low, and it carries the left and right words of the frame that just ended. The playback outputs change only together with the strobe.
- R10: Reset clears the playback outputs, the strobe and the output line. After reset no strobe is given until a complete left half followed by a complete right half has been received.
- R11: Half-frames of up to 64 bit periods (bit clock up to 128 times the word-select rate) are handled in every format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Format code (see R1) |
| bit_clk | input | 1 | Serial bit clock from the master |
| lr_sel | input | 1 | Word select: low = left, high = right |
| ser_in | input | 1 | Serial playback data |
| rec_left | input | 24 | Left record sample to serialise |
| rec_right | input | 24 | Right record sample to serialise |
| ser_out | output | 1 | Serial record data |
| play_left | output | 24 | Received left sample |
| play_right | output | 24 | Received right sample |
| play_valid | output | 1 | One-cycle strobe for a new left/right pair |

## Verification
The bench goes after the places where the alignment rules meet. If the design is off by one bit between delayed and left-aligned modes, every word comes out shifted by one bit. If the right-aligned sign extension is taken from the wrong bit, negative samples turn positive. If the bits above N are not ignored, the upper byte of the playback word is corrupted. It also runs a slot exactly as long as the word, a 16-bit delayed slot that truncates the word, and the 64-bit maximum slot. A design that mis-measured the half-frame length would shift its right-aligned output. One that counted badly after reset would emit a strobe carrying a half-received frame.

// File: rtl/sap_pkg.sv
package sap_pkg;

    parameter int unsigned SAMPLE_W = 24;
    localparam int unsigned LEN_W   = $clog2(SAMPLE_W + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic [1:0] {
        ALIGN_DELAYED = 2'd0,
        ALIGN_LEFT    = 2'd1,
        ALIGN_RIGHT   = 2'd2
    } align_e;

    typedef struct packed {
        align_e           align;
        logic [LEN_W-1:0] len;
    } lane_t;

    typedef struct packed {
        lane_t rx;
        lane_t tx;
    } port_cfg_t;

    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(SAMPLE_W);

    function automatic port_cfg_t decode_fmt(logic [2:0] code);
        port_cfg_t        c;
        logic [LEN_W-1:0] tail;
        case (code[1:0])
            2'b01:   tail = LEN_W'(16);
            2'b10:   tail = LEN_W'(18);
            default: tail = LEN_W'(20);
        endcase
        if (code[1:0] == 2'b00) begin
            c.rx.align = code[2] ? ALIGN_LEFT : ALIGN_DELAYED;
            c.rx.len   = FULL_LEN;
            c.tx       = c.rx;
        end else begin
            c.rx.align = ALIGN_RIGHT;
            c.rx.len   = tail;
            c.tx.align = code[2] ? ALIGN_LEFT : ALIGN_RIGHT;
            c.tx.len   = code[2] ? FULL_LEN : tail;
        end
        return c;
    endfunction

    // Value of the serial bit in period k of a half-frame of 'slot' periods.
    function automatic logic lane_bit(lane_t c, int k, int slot, sample_t w);
        int   j;
        int   start;
        logic b;
        b = 1'b0;
        case (c.align)
            ALIGN_DELAYED: begin
                j = k - 1;
                if (j >= 0 && j < int'(c.len)) b = w[SAMPLE_W-1-j];
            end
            ALIGN_LEFT: begin
                j = k;
                if (j >= 0 && j < int'(c.len)) b = w[SAMPLE_W-1-j];
            end
            default: begin
                start = slot - int'(c.len);
                if (start >= 0 && k >= start && k < slot)
                    b = w[int'(c.len)-1-(k-start)];
            end
        endcase
        return b;
    endfunction

    // Keep the low n bits and sign-extend from bit n-1.
    function automatic sample_t tail_sext(sample_t sr, logic [LEN_W-1:0] n);
        logic signed [SAMPLE_W-1:0] t;
        int sh;
        sh = SAMPLE_W - int'(n);
        t  = sr << sh;
        t  = t >>> sh;
        return sample_t'(t);
    endfunction

endpackage

// File: rtl/sap_edge.sv
module sap_edge #(
    parameter int IN_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_clk,
    input  logic lr_sel,
    input  logic ser_in,
    output logic rise,
    output logic fall,
    output logic ws_s,
    output logic din_s
);
    logic [IN_STAGES-1:0] bq, wq, dq;
    logic                 b_last;

    generate
        if (IN_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    bq <= '0; wq <= '0; dq <= '0;
                end else begin
                    bq <= bit_clk; wq <= lr_sel; dq <= ser_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    bq <= '0; wq <= '0; dq <= '0;
                end else begin
                    bq <= {bq[IN_STAGES-2:0], bit_clk};
                    wq <= {wq[IN_STAGES-2:0], lr_sel};
                    dq <= {dq[IN_STAGES-2:0], ser_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) b_last <= 1'b0;
        else     b_last <= bq[IN_STAGES-1];
    end

    assign rise  =  bq[IN_STAGES-1] & ~b_last;
    assign fall  = ~bq[IN_STAGES-1] &  b_last;
    assign ws_s  =  wq[IN_STAGES-1];
    assign din_s =  dq[IN_STAGES-1];

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
#(
    parameter int MAX_SLOT = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rise,
    input  logic    ws_s,
    input  logic    din_s,
    input  lane_t   cfg,
    output sample_t play_left,
    output sample_t play_right,
    output logic    play_valid
);
    localparam int CW = $clog2(MAX_SLOT);

    logic          ws_prev;
    logic [CW-1:0] rk, rk_nxt;
    sample_t       msb_acc, acc_nxt;
    sample_t       tail_sr;
    sample_t       left_hold;
    sample_t       finalized;
    logic          armed;
    logic          edge_new;
    int            j;
    int            off;

    always_comb begin
        edge_new  = rise && (ws_s != ws_prev);
        finalized = (cfg.align == ALIGN_RIGHT) ? tail_sext(tail_sr, cfg.len) : msb_acc;
        if (edge_new)                      rk_nxt = '0;
        else if (rk == CW'(MAX_SLOT - 1))  rk_nxt = rk;
        else                               rk_nxt = rk + 1'b1;
        off     = (cfg.align == ALIGN_DELAYED) ? 1 : 0;
        j       = int'(rk_nxt) - off;
        acc_nxt = edge_new ? '0 : msb_acc;
        if (cfg.align != ALIGN_RIGHT && j >= 0 && j < int'(cfg.len))
            acc_nxt[SAMPLE_W-1-j] = din_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev    <= 1'b0;
            rk         <= '0;
            msb_acc    <= '0;
            tail_sr    <= '0;
            left_hold  <= '0;
            armed      <= 1'b0;
            play_left  <= '0;
            play_right <= '0;
            play_valid <= 1'b0;
        end else begin
            play_valid <= 1'b0;
            if (rise) begin
                ws_prev <= ws_s;
                rk      <= rk_nxt;
                msb_acc <= acc_nxt;
                tail_sr <= {tail_sr[SAMPLE_W-2:0], din_s};
                if (edge_new) begin
                    if (!ws_prev) begin
                        left_hold <= finalized;
                    end else begin
                        armed <= 1'b1;
                        if (armed) begin
                            play_left  <= left_hold;
                            play_right <= finalized;
                            play_valid <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R9: strobe lasts one cycle
    p_valid_single_r9: assert property (@(posedge clk) disable iff (rst)
        play_valid |=> !play_valid);

    // R9: strobe follows a rising edge seen with word select low
    p_valid_src_r9: assert property (@(posedge clk) disable iff (rst)
        play_valid |-> ($past(rise) && !$past(ws_s)));

    // R9: playback words move only with the strobe
    p_left_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(play_left) |-> play_valid);

    p_right_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(play_right) |-> play_valid);

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
#(
    parameter int MAX_SLOT = 64
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    fall,
    input  logic    ws_s,
    input  lane_t   cfg,
    input  sample_t rec_left,
    input  sample_t rec_right,
    output logic    ser_out
);
    localparam int CW = $clog2(MAX_SLOT);
    localparam int SW = $clog2(MAX_SLOT + 1);

    logic          ws_prev;
    logic [CW-1:0] tk, tk_nxt;
    logic [SW-1:0] slot_len, len_nxt;
    sample_t       word, word_nxt;
    logic          new_half;
    logic          bit_nxt;

    always_comb begin
        new_half = (ws_s != ws_prev);
        if (new_half)                      tk_nxt = '0;
        else if (tk == CW'(MAX_SLOT - 1))  tk_nxt = tk;
        else                               tk_nxt = tk + 1'b1;
        len_nxt  = new_half ? (SW'(tk) + SW'(1)) : slot_len;
        word_nxt = new_half ? (ws_s ? rec_right : rec_left) : word;
        bit_nxt  = lane_bit(cfg, int'(tk_nxt), int'(len_nxt), word_nxt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_prev  <= 1'b0;
            tk       <= '0;
            slot_len <= '0;
            word     <= '0;
            ser_out  <= 1'b0;
        end else if (fall) begin
            ws_prev  <= ws_s;
            tk       <= tk_nxt;
            slot_len <= len_nxt;
            word     <= word_nxt;
            ser_out  <= bit_nxt;
        end
    end

    // R7: the line moves only after a detected falling edge
    p_out_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_out) |-> $past(fall));

endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
    import sap_pkg::*;
#(
    parameter int MAX_SLOT  = 64,
    parameter int IN_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          fmt_sel,
    input  logic                bit_clk,
    input  logic                lr_sel,
    input  logic                ser_in,
    input  logic [SAMPLE_W-1:0] rec_left,
    input  logic [SAMPLE_W-1:0] rec_right,
    output logic                ser_out,
    output logic [SAMPLE_W-1:0] play_left,
    output logic [SAMPLE_W-1:0] play_right,
    output logic                play_valid
);
    port_cfg_t cfg;
    logic      rise, fall, ws_s, din_s;

    assign cfg = decode_fmt(fmt_sel);

    sap_edge #(.IN_STAGES(IN_STAGES)) u_edge (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .lr_sel(lr_sel), .ser_in(ser_in),
        .rise(rise), .fall(fall), .ws_s(ws_s), .din_s(din_s)
    );

    sap_rx #(.MAX_SLOT(MAX_SLOT)) u_rx (
        .clk(clk), .rst(rst), .rise(rise), .ws_s(ws_s), .din_s(din_s), .cfg(cfg.rx),
        .play_left(play_left), .play_right(play_right), .play_valid(play_valid)
    );

    sap_tx #(.MAX_SLOT(MAX_SLOT)) u_tx (
        .clk(clk), .rst(rst), .fall(fall), .ws_s(ws_s), .cfg(cfg.tx),
        .rec_left(rec_left), .rec_right(rec_right), .ser_out(ser_out)
    );

endmodule

// File: tb/serial_audio_port_bench.sv
module serial_audio_port_bench;
    localparam int HB = 4;
    localparam int NV = 11;

    // {fmt, slot, play L, play R, rec L, rec R}
    localparam logic [105:0] VEC [NV] = '{
        {3'b000, 7'd32, 24'hA5C3E1, 24'h1E2D3C, 24'h9ABCDE, 24'h654321},
        {3'b100, 7'd32, 24'h7F0011, 24'h80FF22, 24'hC0FFEE, 24'h0BEEF0},
        {3'b001, 7'd32, 24'hA58001, 24'h5A7FFF, 24'h12ABCD, 24'h34FEDC},
        {3'b010, 7'd24, 24'h3E0000, 24'h41FFFF, 24'h2AAAAA, 24'h155555},
        {3'b011, 7'd32, 24'h180001, 24'h77ABCD, 24'hF12345, 24'h0ABCDE},
        {3'b101, 7'd32, 24'hFF1234, 24'h00ABCD, 24'h876543, 24'h13579B},
        {3'b110, 7'd64, 24'h123456, 24'h3A5A5A, 24'hFEDCBA, 24'h2468AC},
        {3'b111, 7'd20, 24'h9F0F0F, 24'h60F0F0, 24'hABCDEF, 24'h5A5A5A},
        {3'b000, 7'd16, 24'hDEADBE, 24'h0C0FFE, 24'hBEEF01, 24'hCAFE02},
        {3'b100, 7'd64, 24'h800001, 24'h7FFFFE, 24'h0F0F0F, 24'hF0F0F0},
        {3'b011, 7'd64, 24'h0FEDCB, 24'h180000, 24'h9C8B7A, 24'h1D2E3F}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  fmt_sel = 3'b000;
    logic        bit_clk = 1'b1;
    logic        lr_sel = 1'b0;
    logic        ser_in = 1'b0;
    logic [23:0] rec_left = '0;
    logic [23:0] rec_right = '0;
    logic        ser_out;
    logic [23:0] play_left, play_right;
    logic        play_valid;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          vcnt    = 0;
    int          glitch  = 0;
    logic [23:0] got_l = '0;
    logic [23:0] got_r = '0;

    always #5 clk = ~clk;

    serial_audio_port u_serial_audio_port (
        .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .bit_clk(bit_clk), .lr_sel(lr_sel),
        .ser_in(ser_in), .rec_left(rec_left), .rec_right(rec_right), .ser_out(ser_out),
        .play_left(play_left), .play_right(play_right), .play_valid(play_valid)
    );

    always @(negedge clk) begin
        if (!rst && play_valid) begin
            vcnt  = vcnt + 1;
            got_l = play_left;
            got_r = play_right;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // 0 = delayed, 1 = left-aligned, 2 = right-aligned
    function automatic int rx_kind(logic [2:0] f);
        if (f == 3'b000) return 0;
        if (f == 3'b100) return 1;
        return 2;
    endfunction

    function automatic int tx_kind(logic [2:0] f);
        if (f == 3'b000) return 0;
        if (f[2])        return 1;
        return 2;
    endfunction

    function automatic int tail_len(logic [2:0] f);
        if (f[1:0] == 2'b01) return 16;
        if (f[1:0] == 2'b10) return 18;
        return 20;
    endfunction

    function automatic logic put_bit(int kind, int n, int k, int slot, logic [23:0] w);
        if (kind == 0) return (k >= 1 && k <= 24) ? w[24-k] : 1'b0;
        if (kind == 1) return (k < 24) ? w[23-k] : 1'b0;
        if (k >= slot - n && k < slot) return w[slot-1-k];
        return 1'b0;
    endfunction

    function automatic logic [23:0] exp_rx(logic [2:0] f, int slot, logic [23:0] w);
        logic [23:0] r;
        int n;
        r = '0;
        if (rx_kind(f) == 2) begin
            n = tail_len(f);
            for (int i = 0; i < 24; i++) r[i] = (i < n) ? w[i] : w[n-1];
        end else begin
            n = (rx_kind(f) == 0) ? slot - 1 : slot;
            if (n > 24) n = 24;
            for (int i = 0; i < n; i++) r[23-i] = w[23-i];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_tx(logic [2:0] f, int slot, logic [23:0] w);
        logic [63:0] v;
        v = '0;
        for (int k = 0; k < slot; k++) v[k] = put_bit(tx_kind(f), tail_len(f), k, slot, w);
        return v;
    endfunction

    function automatic string rx_tag(logic [2:0] f);
        if (f == 3'b000) return "R1 R2 R3 R8 receive";
        if (f == 3'b100) return "R1 R2 R4 R8 receive";
        return "R1 R2 R5 R8 receive";
    endfunction

    function automatic string tx_tag(logic [2:0] f);
        if (f == 3'b000) return "R2 R3 R7 transmit";
        if (f[2])        return "R2 R4 R7 transmit";
        return "R2 R6 R7 transmit";
    endfunction

    task automatic bit_period(input logic wsv, input logic dv, output logic s);
        bit_clk = 1'b0;
        lr_sel  = wsv;
        ser_in  = dv;
        repeat (HB) @(negedge clk);
        s = ser_out;
        bit_clk = 1'b1;
        repeat (HB) @(negedge clk);
        if (ser_out !== s) glitch++;
    endtask

    task automatic run_frame(input logic [2:0] f, input int slot, input logic [23:0] l,
                             input logic [23:0] r, output logic [63:0] cl, output logic [63:0] cr);
        logic s;
        cl = '0;
        cr = '0;
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < slot; k++) begin
                bit_period(ch[0], put_bit(rx_kind(f), tail_len(f), k, slot, (ch == 0) ? l : r), s);
                if (ch == 0) cl[k] = s;
                else         cr[k] = s;
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] cl, cr, tl, tr;
        int c0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(play_valid == 1'b0 && play_left == '0 && play_right == '0 && ser_out == 1'b0,
              "R10 reset state", {play_valid, play_left, play_right, ser_out}, '0);
        rst = 1'b0;
        @(negedge clk);
        run_frame(3'b000, 32, '0, '0, cl, cr);

        for (int i = 0; i < NV; i++) begin
            logic [105:0] v;
            logic [2:0]   f;
            int           slot;
            logic [23:0]  pl, pr, rl, rr;
            v    = VEC[i];
            f    = v[105:103];
            slot = int'(v[102:96]);
            pl   = v[95:72];
            pr   = v[71:48];
            rl   = v[47:24];
            rr   = v[23:0];
            fmt_sel   = f;
            rec_left  = rl;
            rec_right = rr;
            run_frame(f, slot, '0, '0, cl, cr);
            c0 = vcnt;
            run_frame(f, slot, pl, pr, tl, tr);
            run_frame(f, slot, '0, '0, cl, cr);
            check(got_l == exp_rx(f, slot, pl), {rx_tag(f), " left"}, 64'(got_l), 64'(exp_rx(f, slot, pl)));
            check(got_r == exp_rx(f, slot, pr), {rx_tag(f), " right"}, 64'(got_r), 64'(exp_rx(f, slot, pr)));
            check(tl == exp_tx(f, slot, rl), {tx_tag(f), " left"}, tl, exp_tx(f, slot, rl));
            check(tr == exp_tx(f, slot, rr), {tx_tag(f), " right"}, tr, exp_tx(f, slot, rr));
            check(vcnt - c0 == 2, (slot == 64) ? "R9 R11 strobe count" : "R9 strobe count",
                  64'(vcnt - c0), 64'd2);
        end

        // R10: reset mid-stream, then no strobe until a full left+right pair
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(play_valid == 1'b0 && play_left == '0 && play_right == '0 && ser_out == 1'b0,
              "R10 reset clears outputs", {play_valid, play_left, play_right, ser_out}, '0);
        lr_sel  = 1'b0;
        bit_clk = 1'b1;
        rst     = 1'b0;
        @(negedge clk);
        fmt_sel = 3'b100;
        c0 = vcnt;
        run_frame(3'b100, 32, 24'h111111, 24'h222222, cl, cr);
        run_frame(3'b100, 32, 24'h333333, 24'h444444, cl, cr);
        check(vcnt == c0, "R10 no strobe before a full pair", 64'(vcnt - c0), 64'd0);
        run_frame(3'b100, 32, 24'h555555, 24'h666666, cl, cr);
        check(vcnt == c0 + 1, "R10 first strobe after reset", 64'(vcnt - c0), 64'd1);
        check(got_l == 24'h333333, "R10 R4 first left after reset", 64'(got_l), 64'h333333);
        check(got_r == 24'h444444, "R10 R4 first right after reset", 64'(got_r), 64'h444444);

        // R7: output never moved between a rising edge and the next falling edge
        check(glitch == 0, "R7 output stable outside falling edges", 64'(glitch), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule